// File: doc/BRIEF.md
# Batched Register Access Command Engine

This engine is the responder half of a command mailbox for power-controller registers. When the requester rings the doorbell, the engine looks at the message type, the command id and the size field. It then reads a 16-byte input buffer as a packed batch of up to five 16-bit register addresses, followed by either write data bytes or a value/mask pair. The engine runs the batch as a sequence of byte accesses on a simple synchronous target port that uses request and ready.

Read results land in a 16-byte output buffer in item order. Each command ends with a one-cycle done pulse that carries an error flag and an error code. The requester reads these and, for reads, the output buffer. Commands that are malformed never reach the target.

Top module: `regacc_engine`

## Requirements
- R1: Only message type 0xFF is executed. Any other type ends with err=1 and err_code=0x01, makes no target access, and takes precedence over all other checks.
- R2: Command id 0 is a write, 1 is a read and 2 is a masked read-modify-write. Any other id (with type 0xFF) ends with err=1 and err_code=0x02 and makes no target access.
- R3: Item i's 16-bit address is stored little-endian, with its low byte at input byte 2i and its high byte at input byte 2i+1. Items are accessed in increasing i.
- R4: A read of N items needs size=2N. Result byte i goes to output byte i. Every accepted doorbell clears the output buffer, so output bytes N..15 read zero after a read.
- R5: A write of N items needs size=3N. The data byte for item i is input byte 2N+i.
- R6: A read-modify-write needs size=4 and uses the address at bytes 0..1, the value at byte 2 and the mask at byte 3. It makes one target read, then one target write to the same address of (old & ~mask) | (value & mask).
- R7: A size of zero, a size that is not a whole number of items for the command, or a size that implies more than 5 items ends with err=1 and err_code=0x03 and makes no target access.
- R8: Only one target access is outstanding at a time. Request, address, write-enable and write data hold steady until ready, and the next access starts only after that.
- R9: done is high for exactly one cycle: the cycle after the final target handshake, or the cycle after the doorbell is accepted for a rejected command. err and err_code are valid with done and are 0/0x00 on success.
- R10: A doorbell that arrives while busy is high is ignored. It causes no access and no extra done.
- R11: After reset, busy, done, err, err_code, tgt_req and the output buffer are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bell | input | 1 | Doorbell strobe; accepted only while idle |
| msg_type | input | 8 | Message type of the command |
| cmd_id | input | 4 | Command id (0 write, 1 read, 2 read-modify-write) |
| size_field | input | 8 | Size field of the command, in bytes |
| in_buf | input | 128 | Input buffer; byte k at bits 8k+7:8k |
| out_buf | output | 128 | Read results; byte k at bits 8k+7:8k |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Command failed |
| err_code | output | 8 | 0x00 ok, 0x01 type, 0x02 command, 0x03 size |
| tgt_req | output | 1 | Target access request |
| tgt_we | output | 1 | 1 = write access, 0 = read access |
| tgt_addr | output | 16 | Target register address |
| tgt_wdata | output | 8 | Target write data |
| tgt_ready | input | 1 | Target accepts the access this cycle |
| tgt_rdata | input | 8 | Read data, valid while tgt_ready is high |

## Verification
A wrong item index or count shows up directly on tgt_addr and tgt_wdata. It becomes visible at the first target handshake that differs from the expected order, and as a done pulse that arrives early or late relative to the last handshake. A wrong latched error state is exposed in the done cycle itself, either as a wrong err_code or as target requests that appear for a command that should have been rejected. A merge or result-placement error shows up in the written byte or in the output buffer straight after done. The target model varies its ready latency so that these effects do not hide behind fixed timing.

// File: rtl/regacc_pkg.sv
package regacc_pkg;
  typedef enum logic [1:0] {OP_WR = 2'd0, OP_RD = 2'd1, OP_RMW = 2'd2} op_e;
  typedef enum logic [1:0] {S_IDLE, S_ACC, S_MERGE, S_FIN} st_e;
  localparam logic [7:0] ERR_NONE = 8'h00;
  localparam logic [7:0] ERR_TYPE = 8'h01;
  localparam logic [7:0] ERR_CMD  = 8'h02;
  localparam logic [7:0] ERR_SIZE = 8'h03;
endpackage

// File: rtl/regacc_decode.sv
module regacc_decode
  import regacc_pkg::*;
#(
  parameter int          MAX_ITEMS = 5,
  parameter int          CNT_W     = 3,
  parameter logic [7:0]  MSG_TYPE  = 8'hFF
) (
  input  logic [7:0]       msg_type,
  input  logic [3:0]       cmd_id,
  input  logic [7:0]       size_field,
  output op_e              op,
  output logic [CNT_W-1:0] n_items,
  output logic             bad,
  output logic [7:0]       code
);
  logic [7:0] n_calc;
  logic       size_ok;

  always_comb begin
    op      = OP_WR;
    n_calc  = 8'd0;
    size_ok = 1'b0;
    bad     = 1'b0;
    code    = ERR_NONE;
    unique case (cmd_id)
      4'd0: begin
        op      = OP_WR;
        n_calc  = size_field / 8'd3;
        size_ok = (size_field % 8'd3 == 8'd0);
      end
      4'd1: begin
        op      = OP_RD;
        n_calc  = {1'b0, size_field[7:1]};
        size_ok = !size_field[0];
      end
      4'd2: begin
        op      = OP_RMW;
        n_calc  = 8'd1;
        size_ok = (size_field == 8'd4);
      end
      default: begin
        op      = OP_WR;
        n_calc  = 8'd0;
        size_ok = 1'b0;
      end
    endcase
    if (n_calc == 8'd0 || n_calc > 8'(MAX_ITEMS)) size_ok = 1'b0;
    if (msg_type != MSG_TYPE) begin
      bad  = 1'b1;
      code = ERR_TYPE;
    end else if (cmd_id > 4'd2) begin
      bad  = 1'b1;
      code = ERR_CMD;
    end else if (!size_ok) begin
      bad  = 1'b1;
      code = ERR_SIZE;
    end
  end

  assign n_items = n_calc[CNT_W-1:0];
endmodule

// File: rtl/regacc_seq.sv
module regacc_seq
  import regacc_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  parameter int MAX_ITEMS = 5,
  parameter int CNT_W     = 3,
  parameter int ADDR_W    = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bell,
  input  op_e                    dec_op,
  input  logic [CNT_W-1:0]       dec_n,
  input  logic                   dec_bad,
  input  logic [7:0]             dec_code,
  input  logic [8*BUF_BYTES-1:0] in_buf,
  input  logic                   tgt_ready,
  input  logic [7:0]             tgt_rdata,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic [7:0]             err_code,
  output logic                   start,
  output logic                   rd_wr,
  output logic [CNT_W-1:0]       rd_idx,
  output logic                   tgt_req,
  output logic                   tgt_we,
  output logic [ADDR_W-1:0]      tgt_addr,
  output logic [7:0]             tgt_wdata
);
  localparam int BI_W = $clog2(BUF_BYTES);

  st_e                    st_q, st_d;
  op_e                    op_q, op_d;
  logic [CNT_W-1:0]       n_q, n_d, idx_q, idx_d;
  logic [8*BUF_BYTES-1:0] buf_q, buf_d;
  logic [7:0]             old_q, old_d, code_q, code_d;
  logic                   err_q, err_d;
  logic                   buf_en;
  logic [BI_W-1:0]        lo_i, hi_i, dat_i;
  logic [7:0]             val_b, mask_b, merged;

  assign start  = bell && (st_q == S_IDLE);
  assign buf_en = start;

  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    n_d    = n_q;
    idx_d  = idx_q;
    old_d  = old_q;
    err_d  = err_q;
    code_d = code_q;
    buf_d  = buf_q;
    unique case (st_q)
      S_IDLE: if (bell) begin
        buf_d  = in_buf;
        op_d   = dec_op;
        n_d    = dec_n;
        idx_d  = '0;
        err_d  = dec_bad;
        code_d = dec_code;
        st_d   = dec_bad ? S_FIN : S_ACC;
      end
      S_ACC: if (tgt_ready) begin
        if (op_q == OP_RMW) begin
          old_d = tgt_rdata;
          st_d  = S_MERGE;
        end else if (idx_q == n_q - CNT_W'(1)) begin
          st_d = S_FIN;
        end else begin
          idx_d = idx_q + CNT_W'(1);
        end
      end
      S_MERGE: if (tgt_ready) st_d = S_FIN;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      op_q   <= OP_WR;
      n_q    <= '0;
      idx_q  <= '0;
      old_q  <= '0;
      err_q  <= 1'b0;
      code_q <= ERR_NONE;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      n_q    <= n_d;
      idx_q  <= idx_d;
      old_q  <= old_d;
      err_q  <= err_d;
      code_q <= code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (buf_en) buf_q <= buf_d;
  end

  assign lo_i   = BI_W'({idx_q, 1'b0});
  assign hi_i   = lo_i + BI_W'(1);
  assign dat_i  = BI_W'({n_q, 1'b0}) + BI_W'(idx_q);
  assign val_b  = buf_q[23:16];
  assign mask_b = buf_q[31:24];
  assign merged = (old_q & ~mask_b) | (val_b & mask_b);

  assign tgt_req   = (st_q == S_ACC) || (st_q == S_MERGE);
  assign tgt_we    = (st_q == S_MERGE) || ((st_q == S_ACC) && (op_q == OP_WR));
  assign tgt_addr  = ADDR_W'({buf_q[8*hi_i +: 8], buf_q[8*lo_i +: 8]});
  assign tgt_wdata = (st_q == S_MERGE) ? merged : buf_q[8*dat_i +: 8];

  assign rd_wr    = (st_q == S_ACC) && tgt_ready && (op_q == OP_RD);
  assign rd_idx   = idx_q;
  assign busy     = (st_q != S_IDLE);
  assign done     = (st_q == S_FIN);
  assign err      = err_q;
  assign err_code = code_q;

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req && !tgt_ready |=> tgt_req && $stable(tgt_addr) && $stable(tgt_we) && $stable(tgt_wdata));
  p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bell && busy |=> $stable(op_q) && $stable(n_q));
  p_no_access_on_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && err_q |-> !tgt_req);
  p_err_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err == (err_code != ERR_NONE)));
  p_count_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !err_q |-> (n_q != '0) && (32'(n_q) <= MAX_ITEMS));
endmodule

// File: rtl/regacc_engine.sv
module regacc_engine
  import regacc_pkg::*;
#(
  parameter int         BUF_BYTES = 16,
  parameter int         MAX_ITEMS = 5,
  parameter int         ADDR_W    = 16,
  parameter logic [7:0] MSG_TYPE  = 8'hFF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bell,
  input  logic [7:0]             msg_type,
  input  logic [3:0]             cmd_id,
  input  logic [7:0]             size_field,
  input  logic [8*BUF_BYTES-1:0] in_buf,
  output logic [8*BUF_BYTES-1:0] out_buf,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic [7:0]             err_code,
  output logic                   tgt_req,
  output logic                   tgt_we,
  output logic [ADDR_W-1:0]      tgt_addr,
  output logic [7:0]             tgt_wdata,
  input  logic                   tgt_ready,
  input  logic [7:0]             tgt_rdata
);
  localparam int CNT_W = $clog2(MAX_ITEMS + 1);

  logic [1:0]       rst_sync;
  logic             rst_n_s;
  op_e              dec_op;
  logic [CNT_W-1:0] dec_n, rd_idx;
  logic             dec_bad, start, rd_wr;
  logic [7:0]       dec_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  regacc_decode #(.MAX_ITEMS(MAX_ITEMS), .CNT_W(CNT_W), .MSG_TYPE(MSG_TYPE)) i_decode (
    .msg_type(msg_type), .cmd_id(cmd_id), .size_field(size_field),
    .op(dec_op), .n_items(dec_n), .bad(dec_bad), .code(dec_code)
  );

  regacc_seq #(.BUF_BYTES(BUF_BYTES), .MAX_ITEMS(MAX_ITEMS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_seq (
    .clk(clk), .rst_n(rst_n_s), .bell(bell),
    .dec_op(dec_op), .dec_n(dec_n), .dec_bad(dec_bad), .dec_code(dec_code),
    .in_buf(in_buf), .tgt_ready(tgt_ready), .tgt_rdata(tgt_rdata),
    .busy(busy), .done(done), .err(err), .err_code(err_code),
    .start(start), .rd_wr(rd_wr), .rd_idx(rd_idx),
    .tgt_req(tgt_req), .tgt_we(tgt_we), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata)
  );

  for (genvar b = 0; b < BUF_BYTES; b++) begin : g_out
    logic [7:0] byte_q;
    logic       load;
    assign load = rd_wr && (32'(rd_idx) == b);
    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s)  byte_q <= '0;
      else if (start) byte_q <= '0;
      else if (load)  byte_q <= tgt_rdata;
    end
    assign out_buf[8*b +: 8] = byte_q;
  end

  p_result_slot_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_wr |-> 32'(rd_idx) < MAX_ITEMS);
  p_no_req_idle_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy |-> !tgt_req);
endmodule

// File: tb/test_regacc_engine.sv
module test_regacc_engine;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bell = 1'b0;
  logic [7:0]   msg_type = 8'h00;
  logic [3:0]   cmd_id = 4'h0;
  logic [7:0]   size_field = 8'h00;
  logic [127:0] in_buf = '0;
  logic [127:0] out_buf;
  logic         busy, done, err, tgt_req, tgt_we;
  logic [7:0]   err_code, tgt_wdata;
  logic [15:0]  tgt_addr;
  logic         tgt_ready;
  logic [7:0]   tgt_rdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lat = 0;

  logic [7:0]  mem [256];
  logic        lg_we [64];
  logic [15:0] lg_addr [64];
  logic [7:0]  lg_data [64];
  int          lg_cyc [64];
  int          log_n;
  int          wait_cnt;
  logic        pend;
  logic [15:0] p_addr;
  logic        p_we;
  logic [7:0]  p_data;
  int          hold_bad;

  always #10 clk = ~clk;

  regacc_engine i_regacc_engine (
    .clk(clk), .rst_n(rst_n), .bell(bell), .msg_type(msg_type), .cmd_id(cmd_id),
    .size_field(size_field), .in_buf(in_buf), .out_buf(out_buf), .busy(busy), .done(done),
    .err(err), .err_code(err_code), .tgt_req(tgt_req), .tgt_we(tgt_we), .tgt_addr(tgt_addr),
    .tgt_wdata(tgt_wdata), .tgt_ready(tgt_ready), .tgt_rdata(tgt_rdata)
  );

  always_ff @(posedge clk) cyc <= cyc + 1;

  // target register model with programmable ready latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
      tgt_ready <= 1'b0;
      tgt_rdata <= 8'h00;
      wait_cnt  <= 0;
      log_n     <= 0;
      pend      <= 1'b0;
      hold_bad  <= 0;
    end else begin
      if (pend && !(tgt_req && tgt_addr == p_addr && tgt_we == p_we && tgt_wdata == p_data))
        hold_bad <= hold_bad + 1;
      pend   <= tgt_req && !tgt_ready;
      p_addr <= tgt_addr;
      p_we   <= tgt_we;
      p_data <= tgt_wdata;
      if (tgt_req && tgt_ready) begin
        lg_we[log_n]   <= tgt_we;
        lg_addr[log_n] <= tgt_addr;
        lg_data[log_n] <= tgt_we ? tgt_wdata : tgt_rdata;
        lg_cyc[log_n]  <= cyc;
        log_n          <= log_n + 1;
        if (tgt_we) mem[tgt_addr[7:0]] <= tgt_wdata;
      end
      if (tgt_req && !tgt_ready) begin
        if (wait_cnt >= lat) begin
          tgt_ready <= 1'b1;
          tgt_rdata <= mem[tgt_addr[7:0]];
          wait_cnt  <= 0;
        end else begin
          wait_cnt <= wait_cnt + 1;
        end
      end else begin
        tgt_ready <= 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // issue one command, wait for done, confirm one-cycle pulse
  task automatic run(input logic [7:0] mt, input logic [3:0] ci, input logic [7:0] sz,
                     input logic [127:0] ib, input int l, output int base, output int dcyc);
    @(negedge clk);
    lat = l;
    base = log_n;
    msg_type = mt; cmd_id = ci; size_field = sz; in_buf = ib;
    bell = 1'b1;
    @(negedge clk);
    bell = 1'b0;
    dcyc = -1;
    for (int k = 0; k < 400; k++) begin
      if (done) begin
        dcyc = cyc;
        break;
      end
      @(negedge clk);
    end
    check(dcyc >= 0, "R9 done seen", 0, 1);
    @(negedge clk);
    check(!done, "R9 done single cycle", 128'(done), 0);
  endtask

  task automatic t_reset();
    check(!busy && !done && !err && err_code == 8'h00 && !tgt_req, "R11 reset outputs",
          {busy, done, err, tgt_req, err_code}, 0);
    check(out_buf == '0, "R11 reset out_buf", out_buf, 0);
  endtask

  task automatic t_single_rw();
    int b, d;
    logic [127:0] ib;
    ib = '0; ib[7:0] = 8'h34; ib[15:8] = 8'h12; ib[23:16] = 8'h5A;
    run(8'hFF, 4'd0, 8'd3, ib, 0, b, d);
    check(log_n == b + 1, "R5 single write count", log_n - b, 1);
    check(lg_we[b] && lg_addr[b] == 16'h1234 && lg_data[b] == 8'h5A, "R3 R5 single write",
          {lg_we[b], lg_addr[b], lg_data[b]}, {1'b1, 16'h1234, 8'h5A});
    check(!err && err_code == 8'h00, "R9 success code", {err, err_code}, 0);
    check(d == lg_cyc[b] + 1, "R9 done after last handshake", d, lg_cyc[b] + 1);
    ib = '0; ib[7:0] = 8'h34; ib[15:8] = 8'h12;
    run(8'hFF, 4'd1, 8'd2, ib, 0, b, d);
    check(log_n == b + 1 && !lg_we[b], "R4 single read access", log_n - b, 1);
    check(out_buf == 128'h5A, "R4 single read result, rest zero", out_buf, 128'h5A);
  endtask

  task automatic t_batch_write();
    int b, d;
    logic [127:0] ib;
    ib = '0;
    for (int i = 0; i < 5; i++) begin
      ib[16*i +: 16] = 16'h0200 + 16'(i * 7 + 8'h50);
      ib[8*(10 + i) +: 8] = 8'hC0 + 8'(i);
    end
    run(8'hFF, 4'd0, 8'd15, ib, 2, b, d);
    check(log_n == b + 5, "R5 batch write count", log_n - b, 5);
    for (int i = 0; i < 5; i++) begin
      check(lg_we[b+i] && lg_addr[b+i] == 16'h0200 + 16'(i * 7 + 8'h50) && lg_data[b+i] == 8'hC0 + 8'(i),
            "R3 R5 batch write item order", {lg_addr[b+i], lg_data[b+i]},
            {16'h0200 + 16'(i * 7 + 8'h50), 8'hC0 + 8'(i)});
    end
    check(d == lg_cyc[b+4] + 1, "R9 done timing batch", d, lg_cyc[b+4] + 1);
  endtask

  task automatic t_batch_read();
    int b, d;
    logic [127:0] ib;
    ib = '0;
    ib[15:0]  = 16'h0200 + 16'(4 * 7 + 8'h50);
    ib[31:16] = 16'h0200 + 16'(8'h50);
    ib[47:32] = 16'h0200 + 16'(2 * 7 + 8'h50);
    run(8'hFF, 4'd1, 8'd6, ib, 1, b, d);
    check(log_n == b + 3, "R4 batch read count", log_n - b, 3);
    check(lg_addr[b] == ib[15:0] && lg_addr[b+1] == ib[31:16] && lg_addr[b+2] == ib[47:32],
          "R3 batch read order", lg_addr[b+1], ib[31:16]);
    check(out_buf == 128'hC2_C0_C4, "R4 batch read placement", out_buf, 128'hC2_C0_C4);
  endtask

  task automatic t_rmw();
    int b, d;
    logic [127:0] ib;
    logic [7:0] old, exp;
    old = mem[8'h40];
    exp = (old & ~8'h3C) | (8'h0F & 8'h3C);
    ib = '0; ib[7:0] = 8'h40; ib[15:8] = 8'h80; ib[23:16] = 8'h0F; ib[31:24] = 8'h3C;
    run(8'hFF, 4'd2, 8'd4, ib, 2, b, d);
    check(log_n == b + 2, "R6 rmw two accesses", log_n - b, 2);
    check(!lg_we[b] && lg_addr[b] == 16'h8040, "R6 rmw read first", {lg_we[b], lg_addr[b]}, {1'b0, 16'h8040});
    check(lg_we[b+1] && lg_addr[b+1] == 16'h8040 && lg_data[b+1] == exp, "R6 rmw merged write",
          lg_data[b+1], exp);
    check(!err, "R6 rmw no error", err, 0);
  endtask

  task automatic t_reject(input logic [7:0] mt, input logic [3:0] ci, input logic [7:0] sz,
                          input logic [7:0] code, input string tag);
    int b, d;
    logic [127:0] ib;
    ib = {16{8'h11}};
    run(mt, ci, sz, ib, 0, b, d);
    check(err && err_code == code, tag, {err, err_code}, {1'b1, code});
    check(log_n == b, {tag, " no access"}, log_n - b, 0);
  endtask

  task automatic t_busy_ignore();
    int b, d;
    logic [127:0] ib;
    ib = '0;
    for (int i = 0; i < 5; i++) ib[16*i +: 16] = 16'h0300 + 16'(i + 8'h60);
    @(negedge clk);
    lat = 3; b = log_n;
    msg_type = 8'hFF; cmd_id = 4'd1; size_field = 8'd10; in_buf = ib;
    bell = 1'b1;
    @(negedge clk);
    bell = 1'b0;
    @(negedge clk);
    @(negedge clk);
    cmd_id = 4'd0; size_field = 8'd3; in_buf = {16{8'hEE}};
    bell = 1'b1;
    @(negedge clk);
    bell = 1'b0;
    d = 0;
    for (int k = 0; k < 200; k++) begin
      if (done) d++;
      @(negedge clk);
    end
    check(d == 1, "R10 one done for busy doorbell", d, 1);
    check(log_n == b + 5, "R10 only original accesses", log_n - b, 5);
    for (int i = 0; i < 5; i++)
      check(!lg_we[b+i], "R10 no write from ignored doorbell", lg_we[b+i], 0);
    check(out_buf[39:0] == {8'h64 ^ 8'hA5, 8'h63 ^ 8'hA5, 8'h62 ^ 8'hA5, 8'h61 ^ 8'hA5, 8'h60 ^ 8'hA5},
          "R4 five item read", out_buf[39:0], 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single_rw();
    t_batch_write();
    t_batch_read();
    t_rmw();
    t_reject(8'h7E, 4'd1, 8'd2, 8'h01, "R1 bad type");
    t_reject(8'h00, 4'd9, 8'd7, 8'h01, "R1 type precedence");
    t_reject(8'hFF, 4'd3, 8'd2, 8'h02, "R2 bad command");
    t_reject(8'hFF, 4'd0, 8'd7, 8'h03, "R7 write size not multiple");
    t_reject(8'hFF, 4'd1, 8'd12, 8'h03, "R7 read six items");
    t_reject(8'hFF, 4'd1, 8'd0, 8'h03, "R7 zero size");
    t_reject(8'hFF, 4'd2, 8'd3, 8'h03, "R7 rmw size");
    check(out_buf == '0, "R4 out cleared by accepted doorbell", out_buf, 0);
    t_busy_ignore();
    check(hold_bad == 0, "R8 request held until ready", hold_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule